// File: doc/BRIEF.md
# Two-Channel Ethernet Frame DMA Mover

This block moves 16-bit frame words between the FIFO port of an Ethernet MAC and a byte-addressed memory. It has two channels with fixed roles. Channel 0 carries received frames from the FIFO into memory. Channel 1 carries frames to be sent from memory into the FIFO. Software gives each channel a start address and a word count, then sets its enable bit. From then on the channel moves one word for each grant while the MAC holds that channel's request line high.

For receive, software normally loads the largest count the field can hold. The channel then runs until the MAC marks the last word of the frame. The MAC's active-low end-of-frame strobe reaches the block through an inverter as the active-high `rx_term` input. When `rx_term` is high in the same cycle as a completing receive word, the channel stops. The residual count then tells software how many words arrived.

For transmit, software programs the frame length minus one word. After the done interrupt, software writes the last word through the direct store path. That path pushes the word into the FIFO with the end-of-frame flag raised.

Top module: `frame_dma`

## Requirements
- R1: After synchronous reset the following are all zero: `mem_req`, `irq_rx`, `irq_tx`, `rx_left`, `tx_left`, `fifo_wr` and `fifo_rd`.
- R2: A configuration write selects a channel with `cfg_ch` (0 = receive, 1 = transmit). It selects a field with `cfg_field`: 0 = start address, 1 = word count, 2 = control. In the control field, bit 0 enables the channel and bit 1 clears the done flag. A write of any field to a channel whose enable bit is set has no effect.
- R3: A transfer completes in a cycle with `mem_req` and `mem_ack` both high. `mem_req` stays high until `mem_ack` arrives. Each completed transfer advances the channel's address by 2 and lowers its count by 1. The first transfer uses the programmed start address.
- R4: When the transfer that brings the count to zero completes, the channel clears its enable bit and raises its done interrupt. No further transfer is made for that channel.
- R5: Enabling a channel whose count is zero raises its done interrupt on the next cycle, and no memory request is made.
- R6: A receive transfer drives `mem_wr` = 1 and `mem_wdata` = `fifo_rdata`. It pulses `fifo_rd` in the completing cycle.
- R7: A transmit transfer drives `mem_wr` = 0. In the completing cycle it pulses `fifo_wr` with `fifo_wdata` = `mem_rdata` and `fifo_eof` = 0.
- R8: If `rx_term` is high in the cycle a receive transfer completes, that word is the last one. The receive channel stops and raises its done interrupt, and `rx_left` keeps the programmed count minus the words moved. At any other time `rx_term` has no effect, whether the channel is disabled or is enabled but waiting.
- R9: When both channels are eligible and no transfer is outstanding, channel 0 is granted first.
- R10: While a channel's request input is low, no new transfer starts for it, and its address and count hold. Raising the request again resumes at the next address.
- R11: While the transmit channel is disabled, `sw_store` pushes `sw_data` into the FIFO in the same cycle (`fifo_wr` = 1, `fifo_eof` = 1). While the transmit channel is enabled, `sw_store` is ignored.
- R12: A done interrupt stays high until a control write with bit 1 set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_field | input | 2 | Field selected by the write |
| cfg_wdata | input | 16 | Configuration write data |
| req_rx | input | 1 | Receive word request from the MAC |
| req_tx | input | 1 | Transmit word request from the MAC |
| rx_term | input | 1 | Receive end-of-frame terminate, active high |
| mem_req | output | 1 | Memory access request |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_wr | output | 1 | 1 = memory write (receive), 0 = memory read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Data written to memory |
| mem_rdata | input | 16 | Data read from memory |
| fifo_rd | output | 1 | Pops one word from the MAC receive FIFO |
| fifo_rdata | input | 16 | Head word of the receive FIFO |
| fifo_wr | output | 1 | Pushes one word into the MAC transmit FIFO |
| fifo_wdata | output | 16 | Word pushed into the transmit FIFO |
| fifo_eof | output | 1 | End-of-frame flag for the pushed word |
| sw_store | input | 1 | Direct software store of the final transmit word |
| sw_data | input | 16 | Data for the direct store |
| irq_rx | output | 1 | Receive channel done |
| irq_tx | output | 1 | Transmit channel done |
| rx_left | output | 12 | Receive channel residual count |
| tx_left | output | 12 | Transmit channel residual count |

## Verification
Suppose a channel's address register drifts or skips. The next `mem_addr` presented with an acknowledge is then off from the start-plus-twice-index value, and the error shows at the first word after the fault. Suppose the count is wrong, or a terminate is not sampled with its word. Then the done interrupt rises one or more transfers early or late, and the residual count read after done disagrees with the programmed count less the words observed. Arbitration faults show up as a transmit word appearing before a pending receive burst has drained. A stale enable bit shows up as a direct store being swallowed, or as requests continuing after the interrupt.

// File: rtl/frame_dma_pkg.sv
package frame_dma_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int CNT_W     = 12;
    localparam int NCH       = 2;
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int ADDR_STEP = DATA_W / 8;
    localparam int RX_CH     = 0;
    localparam int TX_CH     = 1;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

    typedef enum logic [1:0] {
        FLD_ADDR  = 2'd0,
        FLD_COUNT = 2'd1,
        FLD_CTRL  = 2'd2
    } cfg_field_e;

    typedef struct packed {
        logic              en;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } chan_state_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return a + ADDR_W'(ADDR_STEP);
    endfunction

endpackage

// File: rtl/frame_dma_chan.sv
module frame_dma_chan
    import frame_dma_pkg::*;
#(
    parameter bit TERM_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        field,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              xfer,
    input  logic              term,
    output chan_state_t       st
);

    chan_state_t nxt;
    logic        last_word;
    logic        cfg_ok;

    assign last_word = (st.cnt == CNT_W'(1)) || (TERM_EN && term);
    assign cfg_ok    = wr_en && !st.en;

    always_comb begin
        nxt = st;
        if (xfer) begin
            nxt.addr = step_addr(st.addr);
            nxt.cnt  = st.cnt - CNT_W'(1);
            if (last_word) begin
                nxt.en   = 1'b0;
                nxt.done = 1'b1;
            end
        end else if (cfg_ok) begin
            case (cfg_field_e'(field))
                FLD_ADDR:  nxt.addr = wdata;
                FLD_COUNT: nxt.cnt  = wdata[CNT_W-1:0];
                FLD_CTRL: begin
                    if (wdata[CTRL_CLR_BIT]) nxt.done = 1'b0;
                    if (wdata[CTRL_EN_BIT]) begin
                        if (st.cnt == '0) nxt.done = 1'b1;
                        else              nxt.en   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (st.addr == $past(st.addr) + ADDR_W'(ADDR_STEP)) &&
                 (st.cnt == $past(st.cnt) - CNT_W'(1)));

    // R4
    xfer_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |-> st.en);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer && !wr_en) |=> $stable(st.addr) && $stable(st.cnt) && $stable(st.en));

    // R12
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st.done && !(cfg_ok && field == FLD_CTRL && wdata[CTRL_CLR_BIT])) |=> st.done);

    // R5
    zero_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_ok && field == FLD_CTRL && wdata[CTRL_EN_BIT] && st.cnt == '0)
        |=> (st.done && !st.en));

endmodule

// File: rtl/frame_dma_arb.sv
module frame_dma_arb
    import frame_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  elig,
    input  logic            ack,
    output logic            busy,
    output logic [CH_W-1:0] cur,
    output logic [NCH-1:0]  fire
);

    logic [CH_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) pick = CH_W'(i);
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            fire[i] = busy && ack && (cur == CH_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (busy && ack) begin
            busy <= 1'b0;
        end else if (!busy && |elig) begin
            busy <= 1'b1;
            cur  <= pick;
        end
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack) |=> (busy && $stable(cur)));

    // R9
    rx_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && elig[RX_CH]) |=> (busy && cur == CH_W'(RX_CH)));

    // R10
    no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && elig == '0) |=> !busy);

endmodule

// File: rtl/frame_dma.sv
module frame_dma
    import frame_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_rx,
    input  logic              req_tx,
    input  logic              rx_term,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fifo_rd,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_eof,
    input  logic              sw_store,
    input  logic [DATA_W-1:0] sw_data,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic [CNT_W-1:0]  rx_left,
    output logic [CNT_W-1:0]  tx_left
);

    chan_state_t     st [NCH];
    logic [NCH-1:0]  req_vec;
    logic [NCH-1:0]  elig;
    logic [NCH-1:0]  fire;
    logic            busy;
    logic [CH_W-1:0] cur;
    logic            sw_ok;

    assign req_vec[RX_CH] = req_rx;
    assign req_vec[TX_CH] = req_tx;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ch_term;
        if (c == RX_CH) begin : g_term
            assign ch_term = rx_term;
        end else begin : g_noterm
            assign ch_term = 1'b0;
        end

        assign elig[c] = st[c].en && req_vec[c];

        frame_dma_chan #(.TERM_EN(c == RX_CH)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .wr_en (cfg_we && (CH_W'(cfg_ch) == CH_W'(c))),
            .field (cfg_field),
            .wdata (cfg_wdata),
            .xfer  (fire[c]),
            .term  (ch_term),
            .st    (st[c])
        );
    end

    frame_dma_arb u_arb (
        .clk  (clk),
        .rst  (rst),
        .elig (elig),
        .ack  (mem_ack),
        .busy (busy),
        .cur  (cur),
        .fire (fire)
    );

    assign mem_req   = busy;
    assign mem_wr    = (cur == CH_W'(RX_CH));
    assign mem_addr  = st[cur].addr;
    assign mem_wdata = fifo_rdata;
    assign fifo_rd   = fire[RX_CH];

    assign sw_ok      = sw_store && !st[TX_CH].en;
    assign fifo_wr    = fire[TX_CH] || sw_ok;
    assign fifo_wdata = sw_ok ? sw_data : mem_rdata;
    assign fifo_eof   = sw_ok;

    assign irq_rx  = st[RX_CH].done;
    assign irq_tx  = st[TX_CH].done;
    assign rx_left = st[RX_CH].cnt;
    assign tx_left = st[TX_CH].cnt;

    // R11
    store_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        fire[TX_CH] |-> !fifo_eof);

    // R6
    rx_pop_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (mem_req && mem_wr));

endmodule

// File: tb/sim_frame_dma.sv
module sim_frame_dma;
    import frame_dma_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_ch = 1'b0;
    logic [1:0]        cfg_field = 2'd0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              req_rx = 1'b0;
    logic              req_tx = 1'b0;
    logic              rx_term;
    logic              mem_req;
    logic              mem_ack = 1'b0;
    logic              mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              fifo_rd;
    logic [DATA_W-1:0] fifo_rdata = '0;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_wdata;
    logic              fifo_eof;
    logic              sw_store = 1'b0;
    logic [DATA_W-1:0] sw_data = '0;
    logic              irq_rx;
    logic              irq_tx;
    logic [CNT_W-1:0]  rx_left;
    logic [CNT_W-1:0]  tx_left;

    logic term_mon = 1'b0;
    logic term_force = 1'b0;
    assign rx_term = term_mon | term_force;

    int n_chk = 0;
    int n_fail = 0;
    int xfer_cnt [2];
    logic [ADDR_W-1:0] exp_addr [2];
    int lat = 0;
    int term_at = 0;
    int wcnt = 0;
    int mon_ch = 0;
    int last_ch = -1;
    int first_ch = -1;
    int switches = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_dma u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .req_rx(req_rx), .req_tx(req_tx), .rx_term(rx_term),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_eof(fifo_eof), .sw_store(sw_store), .sw_data(sw_data),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .rx_left(rx_left), .tx_left(tx_left)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // memory and FIFO model: acknowledges after lat waiting cycles
    always @(negedge clk) begin
        if (rst || !mem_req) begin
            mem_ack  = 1'b0;
            term_mon = 1'b0;
            wcnt     = 0;
        end else if (wcnt < lat) begin
            wcnt++;
        end else begin
            mon_ch     = mem_wr ? 0 : 1;
            wcnt       = 0;
            mem_rdata  = mem_addr ^ 16'h5A5A;
            fifo_rdata = 16'h1000 + DATA_W'(xfer_cnt[0]);
            term_mon   = (mon_ch == 0) && (xfer_cnt[0] + 1 == term_at);
            mem_ack    = 1'b1;
            #1;
            check(mem_addr == exp_addr[mon_ch], "R3 transfer address", mem_addr, exp_addr[mon_ch]);
            if (mon_ch == 0) begin
                check(fifo_rd && !fifo_wr, "R6 receive pop strobe", fifo_rd, 1);
                check(mem_wdata == fifo_rdata, "R6 receive data path", mem_wdata, fifo_rdata);
            end else begin
                check(fifo_wr && !fifo_eof && !fifo_rd, "R7 transmit push strobe", fifo_wr, 1);
                check(fifo_wdata == mem_rdata, "R7 transmit data path", fifo_wdata, mem_rdata);
            end
            xfer_cnt[mon_ch]++;
            exp_addr[mon_ch] = exp_addr[mon_ch] + ADDR_W'(ADDR_STEP);
            if (first_ch < 0) first_ch = mon_ch;
            if (last_ch != mon_ch) switches++;
            last_ch = mon_ch;
        end
    end

    task automatic cfg_write(input logic ch, input logic [1:0] fld, input logic [ADDR_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_stats();
        xfer_cnt[0] = 0; xfer_cnt[1] = 0;
        first_ch = -1; last_ch = -1; switches = 0;
    endtask

    task automatic wait_irq(input int ch);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ((ch == 0) ? irq_rx : irq_tx) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_tx(input logic [ADDR_W-1:0] start, input int n, input int l);
        lat = l;
        clear_stats();
        exp_addr[1] = start;
        cfg_write(1'b1, 2'd0, start);
        cfg_write(1'b1, 2'd1, ADDR_W'(n));
        cfg_write(1'b1, 2'd2, 16'h3);
        req_tx = 1'b1;
        wait_irq(1);
        req_tx = 1'b0;
        check(xfer_cnt[1] == n, "R4 transmit word count", xfer_cnt[1], n);
        check(irq_tx && tx_left == 0, "R4 transmit done and residual", tx_left, 0);
        check(!mem_req, "R4 no request after done", mem_req, 0);
        @(negedge clk);
        sw_store = 1'b1; sw_data = DATA_W'(16'hE000 + n);
        #1;
        check(fifo_wr && fifo_eof && fifo_wdata == DATA_W'(16'hE000 + n),
              "R11 final word store", fifo_wdata, 16'hE000 + n);
        @(negedge clk);
        sw_store = 1'b0;
    endtask

    task automatic run_rx(input logic [ADDR_W-1:0] start, input int cnt, input int k, input int l);
        int exp_n;
        lat = l;
        term_at = k;
        clear_stats();
        exp_addr[0] = start;
        cfg_write(1'b0, 2'd0, start);
        cfg_write(1'b0, 2'd1, ADDR_W'(cnt));
        cfg_write(1'b0, 2'd2, 16'h3);
        req_rx = 1'b1;
        wait_irq(0);
        req_rx = 1'b0;
        exp_n = (k > 0 && k < cnt) ? k : cnt;
        check(xfer_cnt[0] == exp_n, "R8 receive words before terminate", xfer_cnt[0], exp_n);
        check(irq_rx && rx_left == CNT_W'(cnt - exp_n), "R8 receive residual count", rx_left, cnt - exp_n);
        term_at = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R3 act=timeout exp=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_stats();
        exp_addr[0] = '0; exp_addr[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!mem_req && !irq_rx && !irq_tx && !fifo_wr && !fifo_rd, "R1 reset outputs", mem_req, 0);
        check(rx_left == 0 && tx_left == 0, "R1 reset counts", rx_left, 0);

        // R7 R4 transmit sweep over lengths and memory latency
        for (int l = 0; l < 3; l++) begin
            for (int n = 1; n <= 6; n++) begin
                run_tx(ADDR_W'(16'h0100 * n + 16'h0010 * l), n, l);
            end
        end

        // R8 receive with maximum count, terminated at word k
        for (int l = 0; l < 2; l++) begin
            for (int k = 1; k <= 5; k++) begin
                run_rx(ADDR_W'(16'h4000 + 16'h0100 * k), (1 << CNT_W) - 1, k, l);
            end
        end
        // R4 receive ending by count exhaustion
        run_rx(16'h4800, 3, 0, 1);

        // R12 done stays set, cleared only by bit 1
        repeat (5) @(negedge clk);
        check(irq_rx, "R12 done sticky while idle", irq_rx, 1);
        cfg_write(1'b0, 2'd2, 16'h0);
        check(irq_rx, "R12 done kept by control write without clear", irq_rx, 1);
        cfg_write(1'b0, 2'd2, 16'h2);
        check(!irq_rx, "R12 done cleared", irq_rx, 0);

        // R8 terminate while disabled is ignored
        req_rx = 1'b1; term_force = 1'b1;
        repeat (5) @(negedge clk);
        check(!irq_rx && !mem_req, "R8 terminate while disabled ignored", irq_rx, 0);
        req_rx = 1'b0; term_force = 1'b0;

        // R8 terminate while enabled but waiting is ignored
        clear_stats();
        exp_addr[0] = 16'h5000;
        cfg_write(1'b0, 2'd0, 16'h5000);
        cfg_write(1'b0, 2'd1, 16'd5);
        cfg_write(1'b0, 2'd2, 16'h1);
        term_force = 1'b1;
        repeat (3) @(negedge clk);
        term_force = 1'b0;
        check(!irq_rx && rx_left == 5, "R8 terminate without transfer ignored", rx_left, 5);
        req_rx = 1'b1;
        wait_irq(0);
        req_rx = 1'b0;
        check(xfer_cnt[0] == 5, "R8 full count after ignored terminate", xfer_cnt[0], 5);

        // R2 writes ignored while enabled
        clear_stats();
        exp_addr[0] = 16'h2000;
        cfg_write(1'b0, 2'd0, 16'h2000);
        cfg_write(1'b0, 2'd1, 16'd2);
        cfg_write(1'b0, 2'd2, 16'h3);
        cfg_write(1'b0, 2'd0, 16'h3000);
        cfg_write(1'b0, 2'd1, 16'd9);
        check(rx_left == 2, "R2 count write ignored while enabled", rx_left, 2);
        req_rx = 1'b1;
        wait_irq(0);
        req_rx = 1'b0;
        check(xfer_cnt[0] == 2 && rx_left == 0, "R2 original setup used", xfer_cnt[0], 2);

        // R5 enable with zero count
        cfg_write(1'b1, 2'd1, 16'd0);
        cfg_write(1'b1, 2'd2, 16'h2);
        check(!irq_tx, "R12 transmit done cleared", irq_tx, 0);
        cfg_write(1'b1, 2'd2, 16'h1);
        check(irq_tx && !mem_req, "R5 zero count completes at once", irq_tx, 1);

        // R11 store ignored while transmit channel enabled
        clear_stats();
        exp_addr[1] = 16'h0A00;
        cfg_write(1'b1, 2'd0, 16'h0A00);
        cfg_write(1'b1, 2'd1, 16'd2);
        cfg_write(1'b1, 2'd2, 16'h3);
        @(negedge clk);
        sw_store = 1'b1; sw_data = 16'hBEEF;
        #1;
        check(!fifo_wr && !fifo_eof, "R11 store ignored while enabled", fifo_wr, 0);
        @(negedge clk);
        sw_store = 1'b0;
        req_tx = 1'b1;
        wait_irq(1);
        req_tx = 1'b0;
        check(xfer_cnt[1] == 2, "R11 transmit unaffected by dropped store", xfer_cnt[1], 2);

        // R10 pause and resume
        clear_stats();
        lat = 1;
        exp_addr[1] = 16'h0C00;
        cfg_write(1'b1, 2'd0, 16'h0C00);
        cfg_write(1'b1, 2'd1, 16'd6);
        cfg_write(1'b1, 2'd2, 16'h3);
        req_tx = 1'b1;
        wait (xfer_cnt[1] >= 2);
        @(negedge clk);
        req_tx = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            check(!mem_req, "R10 no request while paused", mem_req, 0);
            check(tx_left == CNT_W'(6 - xfer_cnt[1]), "R10 count held while paused", tx_left, 6 - xfer_cnt[1]);
            @(negedge clk);
        end
        req_tx = 1'b1;
        wait_irq(1);
        req_tx = 1'b0;
        check(xfer_cnt[1] == 6 && tx_left == 0, "R10 resumed to completion", xfer_cnt[1], 6);

        // R9 receive wins when both pending
        clear_stats();
        lat = 0;
        exp_addr[0] = 16'h6000;
        exp_addr[1] = 16'h7000;
        cfg_write(1'b0, 2'd0, 16'h6000);
        cfg_write(1'b0, 2'd1, 16'd3);
        cfg_write(1'b0, 2'd2, 16'h3);
        cfg_write(1'b1, 2'd0, 16'h7000);
        cfg_write(1'b1, 2'd1, 16'd3);
        cfg_write(1'b1, 2'd2, 16'h3);
        @(negedge clk);
        req_rx = 1'b1; req_tx = 1'b1;
        wait_irq(1);
        req_rx = 1'b0; req_tx = 1'b0;
        check(first_ch == 0, "R9 receive granted first", first_ch, 0);
        check(switches == 2, "R9 receive burst drains before transmit", switches, 2);
        check(irq_rx && xfer_cnt[0] == 3 && xfer_cnt[1] == 3, "R9 both channels complete", xfer_cnt[0], 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule